// File: doc/BRIEF.md
# Post-increment indirect move engine

This block carries out one memory-to-memory move for a 16-bit processor datapath. On a start strobe it takes the decoded source and destination register numbers, a size bit and two addressing-mode bits. It fetches the opcode word at the program counter. When the destination is indexed, it also fetches a signed offset word that follows the opcode. It then reads the operand from the address held in the source register and writes the operand to its destination. The source register is advanced after the read, by one for a byte move and by two for a word move.

The destination is either a memory location, given by a base register plus the fetched offset, or the destination register itself in the one-word form. Post-increment of the destination is not supported: such a request is rejected at once and flagged. The block holds a sixteen-entry register file and the program counter. Both can be loaded and the register file can be read through side ports. The engine drives one single-port synchronous memory, which returns read data one cycle after the request.

Top module: `ptr_move_engine`

## Requirements
- R1: After synchronous reset, busy, done, err_mode and err_align are 0, the program counter is 0000h and every register reads 0000h.
- R2: The operand is read from the memory address held in the source register, using its value from before the increment. It is written unchanged to the destination: to memory at the indexed address, or to the destination register in the one-word form.
- R3: After a completed move, the source register holds its old value plus 1 for a byte move (byte_op=1) or plus 2 for a word move (byte_op=0), modulo 2^16.
- R4: With dst_indexed=1, the destination address is the destination register value before any increment plus the offset word at PC+2, modulo 2^16, and the PC advances by 4. With dst_indexed=0, the PC advances by 2 and the destination register receives the operand. When the source and destination registers are the same in this form, the operand is written and the increment is discarded. The PC changes only in steps of +2 or through pc_wr_en.
- R5: A start with dst_autoinc=1 is rejected. done rises one cycle later with err_mode=1, no memory access occurs, and no register or PC value changes.
- R6: Byte lanes: a byte operand is taken from bits 7:0 when source address bit 0 is 0, and from bits 15:8 when it is 1. A byte write drives mem_be=01 for an even address or 10 for an odd address, with the byte on both halves of mem_wdata. A word write drives mem_be=11.
- R7: A word move whose source address, or whose indexed destination address, is odd ends with err_align=1 together with done. It performs no memory write and no register update, but the PC keeps its fetch advance.
- R8: done is a one-cycle pulse. Counting the edge that samples start as the first, it comes after 5 edges for an indexed move, 4 for a one-word move, 4 or 3 for an alignment abort (indexed or one-word), and 1 for a rejected request. busy is high from the cycle after start until done.
- R9: A start strobe while busy is high is ignored.
- R10: Memory accesses run in order: opcode read at the PC, offset read at PC+2 (indexed only), operand read, then the destination write. mem_rd and mem_wr are never high together, and neither is high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a move with the command inputs below |
| src_sel | input | 4 | Source pointer register number |
| dst_sel | input | 4 | Destination base or target register number |
| byte_op | input | 1 | 1 = byte move, 0 = word move |
| dst_indexed | input | 1 | 1 = destination is offset(register), two-word form |
| dst_autoinc | input | 1 | Request for destination post-increment (illegal) |
| reg_wr_en | input | 1 | Side write of a register |
| reg_wr_idx | input | 4 | Side write register number |
| reg_wr_data | input | 16 | Side write value |
| reg_rd_idx | input | 4 | Side read register number |
| reg_rd_data | output | 16 | Side read value (combinational) |
| pc_wr_en | input | 1 | Load the program counter |
| pc_wr_data | input | 16 | Program counter load value |
| pc | output | 16 | Program counter |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 16 | Byte address |
| mem_be | output | 2 | Write byte enables (bit 1 = high byte) |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after mem_rd |
| busy | output | 1 | A move is in progress |
| done | output | 1 | One-cycle completion pulse |
| err_mode | output | 1 | Rejected destination post-increment, valid with done |
| err_align | output | 1 | Odd word address abort, valid with done |

## Verification
A wrong sequencer state shows within one cycle as a memory request at the wrong address or in the wrong order, or as a done pulse with the wrong latency. An error in the latched pointer or destination address shows at the operand write, or at the side read port as soon as done is seen. A lane-select fault shows as a wrong byte enable or as a corrupted neighbouring byte in memory. A priority fault between the pointer and destination writes shows as a wrong register value in the same-register one-word case.

// File: rtl/ptm_pkg.sv
`timescale 1ns/1ps
package ptm_pkg;
    localparam int unsigned XLEN  = 16;
    localparam int unsigned NREG  = 16;
    localparam int unsigned RIDX  = $clog2(NREG);
    localparam int unsigned HALF  = XLEN / 2;
    localparam int unsigned LANES = XLEN / 8;
    localparam int unsigned FETCH_STEP = LANES;

    typedef logic [XLEN-1:0]  word_t;
    typedef logic [RIDX-1:0]  ridx_t;
    typedef logic [HALF-1:0]  half_t;
    typedef logic [LANES-1:0] lane_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FOP,
        ST_FEXT,
        ST_RSRC,
        ST_WDST,
        ST_DONE
    } state_e;

    typedef struct packed {
        ridx_t src;
        ridx_t dst;
        logic  byte_op;
        logic  indexed;
    } cmd_t;

    function automatic word_t step_of(input logic is_byte);
        return is_byte ? word_t'(1) : word_t'(LANES);
    endfunction

    function automatic half_t pick_half(input word_t w, input logic hi);
        return hi ? w[XLEN-1:HALF] : w[HALF-1:0];
    endfunction

    function automatic lane_t lane_en(input logic is_byte, input logic hi);
        if (!is_byte) return '1;
        return hi ? lane_t'(2'b10) : lane_t'(2'b01);
    endfunction
endpackage

// File: rtl/ptm_regfile.sv
`timescale 1ns/1ps
module ptm_regfile
    import ptm_pkg::*;
#(
    parameter int unsigned NRD = 3,
    parameter int unsigned NWR = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  ridx_t [NRD-1:0]     rd_idx,
    output word_t [NRD-1:0]     rd_data,
    input  logic  [NWR-1:0]     wr_en,
    input  ridx_t [NWR-1:0]     wr_idx,
    input  word_t [NWR-1:0]     wr_data
);
    word_t regs [NREG];

    // Higher-numbered write ports override lower ones on the same entry.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else begin
            for (int p = 0; p < NWR; p++) begin
                if (wr_en[p]) regs[wr_idx[p]] <= wr_data[p];
            end
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rd_data[r] = regs[rd_idx[r]];
    end
endmodule

// File: rtl/ptm_addr_unit.sv
`timescale 1ns/1ps
module ptm_addr_unit
    import ptm_pkg::*;
(
    input  word_t src_ptr,
    input  word_t dst_base,
    input  word_t offset,
    input  logic  byte_op,
    input  logic  indexed,
    output word_t dst_addr,
    output word_t src_next,
    output logic  misalign
);
    assign dst_addr = dst_base + offset;
    assign src_next = src_ptr + step_of(byte_op);
    assign misalign = !byte_op && (src_ptr[0] || (indexed && dst_addr[0]));
endmodule

// File: rtl/ptm_seq.sv
`timescale 1ns/1ps
module ptm_seq
    import ptm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  cmd_t   cmd_in,
    input  logic   dst_autoinc,
    input  logic   misalign,
    output state_e state,
    output cmd_t   cmd,
    output logic   err_mode,
    output logic   err_align
);
    state_e st_q;
    cmd_t   cmd_q;
    logic   em_q;
    logic   ea_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cmd_q <= '0;
            em_q  <= 1'b0;
            ea_q  <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (start) begin
                    cmd_q <= cmd_in;
                    em_q  <= dst_autoinc;
                    ea_q  <= 1'b0;
                    st_q  <= dst_autoinc ? ST_DONE : ST_FOP;
                end
                ST_FOP:  st_q <= cmd_q.indexed ? ST_FEXT : ST_RSRC;
                ST_FEXT: st_q <= ST_RSRC;
                ST_RSRC: begin
                    ea_q <= misalign;
                    st_q <= misalign ? ST_DONE : ST_WDST;
                end
                ST_WDST: st_q <= ST_DONE;
                ST_DONE: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign state     = st_q;
    assign cmd       = cmd_q;
    assign err_mode  = (st_q == ST_DONE) && em_q;
    assign err_align = (st_q == ST_DONE) && ea_q;
endmodule

// File: rtl/ptr_move_engine.sv
`timescale 1ns/1ps
module ptr_move_engine
    import ptm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [3:0]  src_sel,
    input  logic [3:0]  dst_sel,
    input  logic        byte_op,
    input  logic        dst_indexed,
    input  logic        dst_autoinc,
    input  logic        reg_wr_en,
    input  logic [3:0]  reg_wr_idx,
    input  logic [15:0] reg_wr_data,
    input  logic [3:0]  reg_rd_idx,
    output logic [15:0] reg_rd_data,
    input  logic        pc_wr_en,
    input  logic [15:0] pc_wr_data,
    output logic [15:0] pc,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic [15:0] mem_addr,
    output logic [1:0]  mem_be,
    output logic [15:0] mem_wdata,
    input  logic [15:0] mem_rdata,
    output logic        busy,
    output logic        done,
    output logic        err_mode,
    output logic        err_align
);
    localparam int unsigned RD_SRC = 0;
    localparam int unsigned RD_DST = 1;
    localparam int unsigned RD_EXT = 2;
    localparam int unsigned WP_EXT = 0;
    localparam int unsigned WP_PTR = 1;
    localparam int unsigned WP_DST = 2;

    state_e state;
    cmd_t   cmd;
    cmd_t   cmd_in;
    logic   misalign;

    word_t  pc_q;
    word_t  dst_addr_q;
    word_t  src_next_q;
    logic   src_hi_q;

    ridx_t [2:0] rd_idx;
    word_t [2:0] rd_data;
    logic  [2:0] wr_en;
    ridx_t [2:0] wr_idx;
    word_t [2:0] wr_data;

    word_t src_val;
    word_t dst_val;
    word_t offset;
    word_t dst_addr;
    word_t src_next;
    half_t mv_half;
    word_t mv_reg;

    assign cmd_in = '{src: src_sel, dst: dst_sel, byte_op: byte_op, indexed: dst_indexed};

    ptm_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .cmd_in     (cmd_in),
        .dst_autoinc(dst_autoinc),
        .misalign   (misalign),
        .state      (state),
        .cmd        (cmd),
        .err_mode   (err_mode),
        .err_align  (err_align)
    );

    assign rd_idx[RD_SRC] = cmd.src;
    assign rd_idx[RD_DST] = cmd.dst;
    assign rd_idx[RD_EXT] = reg_rd_idx;
    assign src_val     = rd_data[RD_SRC];
    assign dst_val     = rd_data[RD_DST];
    assign reg_rd_data = rd_data[RD_EXT];

    ptm_regfile #(.NRD(3), .NWR(3)) u_rf (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (rd_idx),
        .rd_data(rd_data),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(wr_data)
    );

    // In the operand-read state the memory returns the offset word fetched before.
    assign offset = cmd.indexed ? mem_rdata : '0;

    ptm_addr_unit u_au (
        .src_ptr (src_val),
        .dst_base(dst_val),
        .offset  (offset),
        .byte_op (cmd.byte_op),
        .indexed (cmd.indexed),
        .dst_addr(dst_addr),
        .src_next(src_next),
        .misalign(misalign)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dst_addr_q <= '0;
            src_next_q <= '0;
            src_hi_q   <= 1'b0;
        end else if (state == ST_RSRC) begin
            dst_addr_q <= dst_addr;
            src_next_q <= src_next;
            src_hi_q   <= src_val[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                                    pc_q <= '0;
        else if (pc_wr_en)                          pc_q <= pc_wr_data;
        else if (state == ST_FOP || state == ST_FEXT) pc_q <= pc_q + word_t'(FETCH_STEP);
    end
    assign pc = pc_q;

    assign mv_half   = pick_half(mem_rdata, src_hi_q);
    assign mv_reg    = cmd.byte_op ? {half_t'(0), mv_half} : mem_rdata;
    assign mem_wdata = cmd.byte_op ? {mv_half, mv_half} : mem_rdata;

    always_comb begin
        mem_rd   = 1'b0;
        mem_wr   = 1'b0;
        mem_addr = '0;
        mem_be   = '0;
        unique case (state)
            ST_FOP, ST_FEXT: begin
                mem_rd   = 1'b1;
                mem_addr = pc_q;
            end
            ST_RSRC: begin
                mem_rd   = !misalign;
                mem_addr = src_val;
            end
            ST_WDST: if (cmd.indexed) begin
                mem_wr   = 1'b1;
                mem_addr = dst_addr_q;
                mem_be   = lane_en(cmd.byte_op, dst_addr_q[0]);
            end
            default: ;
        endcase
    end

    assign wr_en[WP_EXT]   = reg_wr_en;
    assign wr_idx[WP_EXT]  = reg_wr_idx;
    assign wr_data[WP_EXT] = reg_wr_data;
    assign wr_en[WP_PTR]   = (state == ST_WDST);
    assign wr_idx[WP_PTR]  = cmd.src;
    assign wr_data[WP_PTR] = src_next_q;
    assign wr_en[WP_DST]   = (state == ST_WDST) && !cmd.indexed;
    assign wr_idx[WP_DST]  = cmd.dst;
    assign wr_data[WP_DST] = mv_reg;

    assign busy = (state != ST_IDLE);
    assign done = (state == ST_DONE);
endmodule

// File: rtl/ptm_move_chk.sv
`timescale 1ns/1ps
module ptm_move_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        err_mode,
    input logic        err_align,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic [1:0]  mem_be,
    input logic        mem_addr_lsb,
    input logic [15:0] pc,
    input logic        pc_wr_en
);
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_busy_after_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    a_r5_reject_next_cycle: assert property (@(posedge clk) disable iff (rst)
        (done && err_mode) |-> ($past(start) && !$past(busy)));

    a_r7_flags_only_with_done: assert property (@(posedge clk) disable iff (rst)
        (err_mode || err_align) |-> done);

    a_r7_word_write_even: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && mem_be == 2'b11) |-> !mem_addr_lsb);

    a_r6_byte_lane_match: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && $countones(mem_be) == 1) |-> (mem_be[1] == mem_addr_lsb));

    a_r6_write_has_lane: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (mem_be != 2'b00));

    a_r10_single_access: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    a_r10_access_when_busy: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr) |-> busy);

    a_r4_pc_steps_by_two: assert property (@(posedge clk) disable iff (rst)
        (!$past(pc_wr_en) && pc != $past(pc)) |-> (pc == $past(pc) + 16'd2));
endmodule

bind ptr_move_engine ptm_move_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .err_mode    (err_mode),
    .err_align   (err_align),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .mem_be      (mem_be),
    .mem_addr_lsb(mem_addr[0]),
    .pc          (pc),
    .pc_wr_en    (pc_wr_en)
);

// File: tb/ptr_move_engine_tb.sv
`timescale 1ns/1ps
module ptr_move_engine_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        start = 1'b0;
    logic [3:0]  src_sel = '0, dst_sel = '0;
    logic        byte_op = 1'b0, dst_indexed = 1'b0, dst_autoinc = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_wr_idx = '0;
    logic [15:0] reg_wr_data = '0;
    logic [3:0]  reg_rd_idx = '0;
    logic [15:0] reg_rd_data;
    logic        pc_wr_en = 1'b0;
    logic [15:0] pc_wr_data = '0;
    logic [15:0] pc;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_addr, mem_wdata;
    logic [1:0]  mem_be;
    logic [15:0] mem_rdata = '0;
    logic        busy, done, err_mode, err_align;

    int total = 0;
    int bad   = 0;

    logic [15:0] mem [4096];
    logic        fill_req = 1'b0, poke_en = 1'b0, log_en = 1'b0, log_clr = 1'b0;
    logic [15:0] poke_a = '0, poke_v = '0;
    logic [15:0] rd_log [8];
    logic [15:0] wr_log = '0;
    int          rd_n = 0, wr_n = 0;

    function automatic logic [15:0] pat(input int i);
        return 16'(i * 951) ^ 16'hA55A;
    endfunction

    always @(posedge clk) begin
        if (fill_req) for (int i = 0; i < 4096; i++) mem[i] <= pat(i);
        if (poke_en) mem[poke_a[12:1]] <= poke_v;
        if (mem_rd) mem_rdata <= mem[mem_addr[12:1]];
        if (mem_wr) begin
            if (mem_be[0]) mem[mem_addr[12:1]][7:0]  <= mem_wdata[7:0];
            if (mem_be[1]) mem[mem_addr[12:1]][15:8] <= mem_wdata[15:8];
        end
        if (log_clr) begin
            rd_n <= 0;
            wr_n <= 0;
        end else if (log_en) begin
            if (mem_rd && rd_n < 8) begin
                rd_log[rd_n] <= mem_addr;
                rd_n <= rd_n + 1;
            end
            if (mem_wr) begin
                wr_log <= mem_addr;
                wr_n <= wr_n + 1;
            end
        end
    end

    ptr_move_engine u_dut (
        .clk(clk), .rst(rst), .start(start), .src_sel(src_sel), .dst_sel(dst_sel),
        .byte_op(byte_op), .dst_indexed(dst_indexed), .dst_autoinc(dst_autoinc),
        .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx), .reg_wr_data(reg_wr_data),
        .reg_rd_idx(reg_rd_idx), .reg_rd_data(reg_rd_data),
        .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data), .pc(pc),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .err_mode(err_mode), .err_align(err_align)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic fill();
        fill_req = 1'b1;
        @(negedge clk);
        fill_req = 1'b0;
    endtask

    task automatic poke(input logic [15:0] a, input logic [15:0] v);
        poke_en = 1'b1; poke_a = a; poke_v = v;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic set_reg(input logic [3:0] idx, input logic [15:0] v);
        reg_wr_en = 1'b1; reg_wr_idx = idx; reg_wr_data = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic set_pc(input logic [15:0] v);
        pc_wr_en = 1'b1; pc_wr_data = v;
        @(negedge clk);
        pc_wr_en = 1'b0;
    endtask

    task automatic get_reg(input logic [3:0] idx, output logic [15:0] v);
        reg_rd_idx = idx;
        #1;
        v = reg_rd_data;
        @(negedge clk);
    endtask

    task automatic clear_log();
        log_clr = 1'b1;
        @(negedge clk);
        log_clr = 1'b0;
        log_en  = 1'b1;
    endtask

    // Returns at the falling edge where done is seen; lat counts rising edges from start.
    task automatic run_op(input logic [3:0] s, input logic [3:0] d, input logic sz,
                          input logic ix, input logic ai, input logic noise, output int lat);
        src_sel = s; dst_sel = d; byte_op = sz; dst_indexed = ix; dst_autoinc = ai;
        start = 1'b1;
        lat = 0;
        do begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (lat == 1) begin
                chk("R8 busy after start", busy, 1);
                start = noise;
                if (noise) dst_autoinc = 1'b1;
            end else if (lat == 2) begin
                start = 1'b0;
                dst_autoinc = 1'b0;
            end
        end while (!done && lat < 16);
        start = 1'b0;
        dst_autoinc = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R8 actual=hung expected=done");
        summary();
    end

    initial begin
        logic [15:0] v, sv, dv, off, pc0, da, w, orig, expm, mvr;
        logic [7:0]  mvb;
        logic        fault;
        int          lat, cnt;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 err_mode", err_mode, 0);
        chk("R1 err_align", err_align, 0);
        chk("R1 pc", pc, 0);
        for (int r = 0; r < 16; r++) begin
            get_reg(4'(r), v);
            chk("R1 register zero", v, 0);
        end

        // Sweep over size, destination form, address parity and register aliasing
        for (int sz = 0; sz < 2; sz++)
        for (int ix = 0; ix < 2; ix++)
        for (int sp = 0; sp < 2; sp++)
        for (int dp = 0; dp < 2; dp++)
        for (int same = 0; same < 2; same++) begin
            fill();
            sv  = 16'h0200 | 16'(sp);
            dv  = (same != 0) ? sv : (16'h0400 | 16'(dp));
            off = (ix != 0) ? (16'h0010 + 16'(4 * sz)) : 16'h0000;
            pc0 = 16'h0100;
            poke(pc0 + 16'd2, off);
            set_reg(4'd3, sv);
            if (same == 0) set_reg(4'd7, dv);
            set_pc(pc0);
            run_op(4'd3, (same != 0) ? 4'd3 : 4'd7, sz[0], ix[0], 1'b0, 1'b0, lat);
            da    = dv + off;
            fault = (sz == 0) && (sv[0] || ((ix != 0) && da[0]));
            w     = pat(int'(sv[12:1]));
            mvb   = sv[0] ? w[15:8] : w[7:0];
            mvr   = (sz != 0) ? {8'h00, mvb} : w;
            chk("R8 latency", lat, fault ? ((ix != 0) ? 4 : 3) : ((ix != 0) ? 5 : 4));
            chk("R7 err_align", err_align, fault);
            chk("R5 err_mode clear", err_mode, 0);
            chk("R4 pc advance", pc, pc0 + ((ix != 0) ? 16'd4 : 16'd2));
            get_reg(4'd3, v);
            if (fault)                        chk("R7 pointer kept", v, sv);
            else if (ix == 0 && same != 0)    chk("R4 same reg data wins", v, mvr);
            else                              chk("R3 pointer increment", v, sv + ((sz != 0) ? 16'd1 : 16'd2));
            if (same == 0) begin
                get_reg(4'd7, v);
                if (ix == 0 && !fault) chk("R2 register destination", v, mvr);
                else                   chk("R2 destination reg untouched", v, dv);
            end
            if (ix != 0) begin
                orig = pat(int'(da[12:1]));
                if (fault)          expm = orig;
                else if (sz == 0)   expm = w;
                else if (da[0])     expm = {mvb, orig[7:0]};
                else                expm = {orig[15:8], mvb};
                chk("R6 indexed memory destination", mem[da[12:1]], expm);
            end
        end

        // Worked example: word move through an incremented pointer into offset(Rd)
        fill();
        poke(16'hFF14, 16'h4ABB);
        poke(16'hFF16, 16'h0000);
        poke(16'hFA32, 16'h5BC1);
        set_reg(4'd10, 16'hFA32);
        set_reg(4'd11, 16'h10A8);
        set_pc(16'hFF14);
        clear_log();
        run_op(4'd10, 4'd11, 1'b0, 1'b1, 1'b0, 1'b0, lat);
        log_en = 1'b0;
        chk("R8 indexed latency", lat, 5);
        chk("R2 example memory", mem[16'h10A8 >> 1], 16'h5BC1);
        chk("R4 example pc", pc, 16'hFF18);
        get_reg(4'd10, v);
        chk("R3 example pointer", v, 16'hFA34);
        chk("R10 read count", rd_n, 3);
        chk("R10 first read opcode", rd_log[0], 16'hFF14);
        chk("R10 second read offset", rd_log[1], 16'hFF16);
        chk("R10 third read operand", rd_log[2], 16'hFA32);
        chk("R10 write count", wr_n, 1);
        chk("R10 write address", wr_log, 16'h10A8);

        // Destination post-increment request is rejected
        fill();
        set_reg(4'd4, 16'h0300);
        set_reg(4'd5, 16'h0500);
        set_pc(16'h0120);
        clear_log();
        run_op(4'd4, 4'd5, 1'b0, 1'b1, 1'b1, 1'b0, lat);
        chk("R5 reject latency", lat, 1);
        chk("R5 err_mode", err_mode, 1);
        chk("R5 no align flag", err_align, 0);
        @(negedge clk);
        log_en = 1'b0;
        chk("R5 no memory reads", rd_n, 0);
        chk("R5 no memory writes", wr_n, 0);
        chk("R5 pc unchanged", pc, 16'h0120);
        get_reg(4'd4, v);
        chk("R5 source unchanged", v, 16'h0300);
        get_reg(4'd5, v);
        chk("R5 destination unchanged", v, 16'h0500);
        cnt = 0;
        for (int i = 0; i < 4096; i++) if (mem[i] !== pat(i)) cnt++;
        chk("R5 memory unchanged", cnt, 0);

        // PC and indexed address wrap modulo 2^16
        fill();
        poke(16'hFFFE, 16'h0020);
        set_reg(4'd2, 16'h0300);
        set_reg(4'd6, 16'hFFF0);
        set_pc(16'hFFFC);
        run_op(4'd2, 4'd6, 1'b0, 1'b1, 1'b0, 1'b0, lat);
        chk("R4 pc wrap", pc, 16'h0000);
        chk("R4 indexed address wrap", mem[16'h0010 >> 1], pat(16'h0300 >> 1));
        get_reg(4'd2, v);
        chk("R3 pointer word step", v, 16'h0302);

        // Pointer wrap, byte from the high lane into a register
        fill();
        set_reg(4'd8, 16'hFFFF);
        set_pc(16'h0140);
        run_op(4'd8, 4'd9, 1'b1, 1'b0, 1'b0, 1'b0, lat);
        chk("R8 one-word latency", lat, 4);
        get_reg(4'd8, v);
        chk("R3 byte pointer wrap", v, 16'h0000);
        get_reg(4'd9, v);
        w = pat(4095);
        chk("R6 high lane byte zero-extended", v, {8'h00, w[15:8]});

        // Pointer wrap, word step
        set_reg(4'd8, 16'hFFFE);
        run_op(4'd8, 4'd9, 1'b0, 1'b0, 1'b0, 1'b0, lat);
        get_reg(4'd8, v);
        chk("R3 word pointer wrap", v, 16'h0000);
        get_reg(4'd9, v);
        chk("R2 word into register", v, pat(4095));

        // Start strobe while busy is ignored
        fill();
        poke(16'h0182, 16'h0000);
        set_reg(4'd10, 16'h0300);
        set_reg(4'd11, 16'h0600);
        set_pc(16'h0180);
        run_op(4'd10, 4'd11, 1'b0, 1'b1, 1'b0, 1'b1, lat);
        chk("R9 latency with extra strobe", lat, 5);
        chk("R9 no mode error", err_mode, 0);
        cnt = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (done) cnt++;
        end
        chk("R9 single done", cnt, 0);
        chk("R9 idle after", busy, 0);
        chk("R9 pc advanced once", pc, 16'h0184);
        chk("R9 memory result", mem[16'h0600 >> 1], pat(16'h0300 >> 1));
        get_reg(4'd10, v);
        chk("R9 pointer advanced once", v, 16'h0302);

        summary();
    end
endmodule